// File: doc/BRIEF.md
# Two-Channel Wiper Register Controller with Two-Wire Slave

This block is the digital front end of a two-channel programmable resistor. It is a slave on a two-wire serial bus (I2C-style open-drain SCL and SDA). It holds one 8-bit wiper code for each channel, a shutdown flag and two general-purpose logic outputs, and presents all of them as parallel outputs to the analog side.

SCL and SDA are sampled on a faster system clock. Each passes through a synchronizer and then edge detection. A transfer to the slave carries three bytes:
- an address byte;
- an instruction byte, which picks the channel and sets the midscale-reset, shutdown and output bits;
- an optional data byte, which becomes the new code of the chosen channel.

Because the instruction byte is separate from the data, a master can change the logic outputs or the shutdown flag without disturbing either wiper. A read returns the code of the channel named by the most recent instruction.

The block drives SDA only through `sda_oe`. When `sda_oe` is high, the pad pulls the line low. All the other pins are plain level signals with no handshake, because every register bit reaches its output directly.

Top module: `i2c_dpot_ctrl`

## Requirements
- R1: After reset, both wiper outputs hold 0x80, `gpo` is 0, `shutdown` is 0 and `sda_oe` is 0.
- R2: The address byte is sent MSB first and has the layout 0,1,0,1,1,AD1,AD0,RW. AD1 is bit 2 and AD0 is bit 1, and RW=1 means read. The slave acknowledges (`sda_oe` high through the ninth clock) only when AD1:AD0 equals `addr_pins[1:0]`.
- R3: After an address mismatch, the slave acknowledges nothing and changes no register until the next START or STOP.
- R4: The instruction byte fields are:
  - bit 7: channel select (0 = `wiper_a`, 1 = `wiper_b`);
  - bit 6: midscale reset;
  - bit 5: shutdown;
  - bit 4: `gpo[0]`;
  - bit 3: `gpo[1]`;
  - bits 2:0: ignored.
  The slave acknowledges every instruction byte.
- R5: A data byte that follows the instruction byte is acknowledged and loaded into the selected wiper. The other wiper keeps its value.
- R6: A STOP right after the instruction byte's acknowledge updates `gpo`, `shutdown` and the channel selection, and leaves both wipers unchanged.
- R7: An instruction with midscale reset set forces the selected wiper to 0x80. A data byte in the same transfer is acknowledged but not loaded.
- R8: A read returns the wiper of the most recently selected channel, MSB first. The slave sends the same byte again while the master acknowledges, and releases SDA after a master NACK.
- R9: A repeated START without a STOP begins a new address/instruction sequence, and that sequence takes effect.
- R10: In a write, bytes after the data byte are neither acknowledged nor applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or read data 0) |
| addr_pins | input | 2 | Strap levels compared with AD1:AD0 |
| wiper_a | output | 8 | Code of channel 0 |
| wiper_b | output | 8 | Code of channel 1 |
| shutdown | output | 1 | Shutdown flag from the last instruction |
| gpo | output | 2 | General-purpose logic outputs |

## Verification
The bench sweeps all four strap values against all four addressed values.
- A slave that compares the wrong bits would acknowledge a stranger, or would go on to apply a stranger's instruction after the mismatch.
- Wiper codes including 0x00 and 0xFF are written to both channels and read back over the bus. This exposes a swapped channel select, a bit-order error in the read shifter, and an SDA that stays driven after the NACK.
- Instruction-only writes, midscale-with-data writes, trailing extra bytes and repeated STARTs target the cases where a careless sequencer would corrupt a wiper that should have been left alone.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  localparam int WIPER_W = 8;
  localparam int NUM_CH  = 2;
  localparam int BYTE_W  = 8;
  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

  // instruction byte field positions (decoded by the register bank)
  localparam int IB_SEL = 7;
  localparam int IB_RS  = 6;
  localparam int IB_SD  = 5;
  localparam int IB_G0  = 4;
  localparam int IB_G1  = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD_BYTE, ST_RD_ACK, ST_IGNORE
  } link_state_t;
endpackage

// File: rtl/i2c_pin_sync.sv
`timescale 1ns/1ps
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_now   = sda_pipe[STAGES-1];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/i2c_dpot_link.sv
`timescale 1ns/1ps
module i2c_dpot_link
  import dpot_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [1:0]         addr_pins,
  input  logic [WIPER_W-1:0] rd_val,
  output logic               sda_oe,
  output logic               instr_we,
  output logic               data_we,
  output logic [BYTE_W-1:0]  rx_byte,
  output link_state_t        state_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  link_state_t       state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q;
  logic              master_ack;
  logic              byte_full;
  logic              addr_hit;

  assign byte_full = (cnt == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg[BYTE_W-1:1] == {ADDR_FIXED, addr_pins});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      rw_q       <= 1'b0;
      master_ack <= 1'b0;
      sda_oe     <= 1'b0;
      instr_we   <= 1'b0;
      data_we    <= 1'b0;
    end else begin
      instr_we <= 1'b0;
      data_we  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_INSTR, ST_DATA: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && byte_full) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw_q   <= shreg[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_INSTR) begin
                sda_oe   <= 1'b1;
                instr_we <= 1'b1;
                state    <= ST_INSTR_ACK;
              end else begin
                sda_oe  <= 1'b1;
                data_we <= 1'b1;
                state   <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                shreg  <= rd_val;
                sda_oe <= ~rd_val[WIPER_W-1];
                cnt    <= '0;
                state  <= ST_RD_BYTE;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_INSTR;
              end
            end
          end
          ST_INSTR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RD_ACK;
              end else begin
                shreg  <= shreg << 1;
                sda_oe <= ~shreg[BYTE_W-2];
                cnt    <= cnt + CNT_W'(1);
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (master_ack) begin
                shreg  <= rd_val;
                sda_oe <= ~rd_val[WIPER_W-1];
                state  <= ST_RD_BYTE;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte = shreg;
  assign state_o = state;
endmodule

// File: rtl/dpot_regs.sv
`timescale 1ns/1ps
module dpot_regs
  import dpot_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      instr_we,
  input  logic                      data_we,
  input  logic [BYTE_W-1:0]         rx_byte,
  output logic [NUM_CH*WIPER_W-1:0] wipers,
  output logic [WIPER_W-1:0]        rd_val,
  output logic                      shdn,
  output logic [1:0]                gpo
);
  logic [WIPER_W-1:0] wiper_q [NUM_CH];
  logic sel_q;
  logic rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      rs_q  <= 1'b0;
      shdn  <= 1'b0;
      gpo   <= 2'b00;
    end else if (instr_we) begin
      sel_q <= rx_byte[IB_SEL];
      rs_q  <= rx_byte[IB_RS];
      shdn  <= rx_byte[IB_SD];
      gpo   <= {rx_byte[IB_G1], rx_byte[IB_G0]};
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[g] <= MIDSCALE;
      end else if (instr_we && rx_byte[IB_RS] && (rx_byte[IB_SEL] == 1'(g))) begin
        wiper_q[g] <= MIDSCALE;
      end else if (data_we && !rs_q && (sel_q == 1'(g))) begin
        wiper_q[g] <= rx_byte;
      end
    end
    assign wipers[g*WIPER_W +: WIPER_W] = wiper_q[g];
  end

  assign rd_val = wiper_q[sel_q];
endmodule

// File: rtl/i2c_dpot_ctrl.sv
`timescale 1ns/1ps
module i2c_dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIXED  = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [1:0]         addr_pins,
  output logic [WIPER_W-1:0] wiper_a,
  output logic [WIPER_W-1:0] wiper_b,
  output logic               shutdown,
  output logic [1:0]         gpo
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic instr_we, data_we;
  logic [BYTE_W-1:0] rx_byte;
  logic [WIPER_W-1:0] rd_val;
  logic [NUM_CH*WIPER_W-1:0] wipers;
  link_state_t link_state;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_dpot_link #(.ADDR_FIXED(ADDR_FIXED)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_pins(addr_pins), .rd_val(rd_val), .sda_oe(sda_oe),
    .instr_we(instr_we), .data_we(data_we), .rx_byte(rx_byte),
    .state_o(link_state)
  );

  dpot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .data_we(data_we),
    .rx_byte(rx_byte), .wipers(wipers), .rd_val(rd_val),
    .shdn(shutdown), .gpo(gpo)
  );

  assign wiper_a = wipers[0 +: WIPER_W];
  assign wiper_b = wipers[WIPER_W +: WIPER_W];
endmodule

// File: rtl/dpot_checker.sv
`timescale 1ns/1ps
module dpot_checker
  import dpot_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic               scl_fall,
  input logic               instr_we,
  input logic               data_we,
  input logic [WIPER_W-1:0] wiper_a,
  input logic [WIPER_W-1:0] wiper_b,
  input logic [1:0]         gpo,
  input logic               shutdown,
  input link_state_t        link_state
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper_a == MIDSCALE && wiper_b == MIDSCALE && gpo == 2'b00 && !shutdown));

  a_r2_drive_after_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  a_r3_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == ST_IGNORE) |-> !sda_oe);

  a_r5_wiper_a_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_a) |-> $past(instr_we || data_we));

  a_r5_wiper_b_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_b) |-> $past(instr_we || data_we));

  a_r6_gpo_needs_instr: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({gpo, shutdown}) |-> $past(instr_we));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_we && data_we));
endmodule

bind i2c_dpot_ctrl dpot_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .instr_we(instr_we), .data_we(data_we), .wiper_a(wiper_a),
  .wiper_b(wiper_b), .gpo(gpo), .shutdown(shutdown), .link_state(link_state)
);

// File: tb/sim_i2c_dpot_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_dpot_ctrl;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] pins = 2'b00;
  logic sda_oe, shutdown;
  logic [7:0] wiper_a, wiper_b;
  logic [1:0] gpo;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  logic [7:0] exp_w [2];
  logic exp_sel, exp_sd, exp_rs;
  logic [1:0] exp_gpo;

  always #2.5 clk = ~clk;

  i2c_dpot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pins(pins), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .shutdown(shutdown), .gpo(gpo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q); b = {b[6:0], sda_bus}; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = nack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic void model_instr(input logic [7:0] ins);
    exp_sel = ins[7]; exp_rs = ins[6]; exp_sd = ins[5];
    exp_gpo = {ins[3], ins[4]};
    if (ins[6]) exp_w[ins[7]] = 8'h80;
  endfunction

  function automatic void model_data(input logic [7:0] d);
    if (!exp_rs) exp_w[exp_sel] = d;
  endfunction

  task automatic check_regs(input string tag);
    chk({tag, " wiper_a"}, wiper_a, exp_w[0]);
    chk({tag, " wiper_b"}, wiper_b, exp_w[1]);
    chk({tag, " gpo"}, gpo, exp_gpo);
    chk({tag, " shutdown"}, shutdown, exp_sd);
  endtask

  task automatic do_read(input logic [1:0] ad, input int nbytes, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    wr_byte({5'b01011, ad, 1'b1}, a);
    chk({tag, " R2 read addr ack"}, a, 1);
    for (int k = 0; k < nbytes; k++) begin
      rd_byte(k == nbytes - 1, b);
      chk({tag, " R8 read value"}, b, exp_w[exp_sel]);
    end
    chk({tag, " R8 released after NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] ins, dat;
    exp_w[0] = 8'h80; exp_w[1] = 8'h80;
    exp_sel = 0; exp_sd = 0; exp_rs = 0; exp_gpo = 2'b00;
    tick(10);
    rst_n = 1'b1;
    tick(4);
    check_regs("R1 reset");
    chk("R1 sda_oe", sda_oe, 0);

    // R2/R3: strap vs addressed value sweep
    for (int p = 0; p < 4; p++) begin
      pins = 2'(p);
      for (int ad = 0; ad < 4; ad++) begin
        ins = {ad[0], 1'b0, ad[1], p[0], p[1], 3'b101};
        dat = 8'(p * 64 + ad * 16 + 5);
        bus_start();
        wr_byte({5'b01011, 2'(ad), 1'b0}, a0);
        wr_byte(ins, a1);
        wr_byte(dat, a2);
        bus_stop();
        chk("R2 address ack", a0, int'(ad == p));
        chk("R3 instr ack follows address", a1, int'(ad == p));
        chk("R3 data ack follows address", a2, int'(ad == p));
        if (ad == p) begin
          model_instr(ins);
          model_data(dat);
        end
        check_regs("R3/R4 after addressed write");
      end
    end

    // R5/R8: data sweep on both channels with readback
    pins = 2'b10;
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 8; k++) begin
        dat = (k == 0) ? 8'h00 : (k == 7) ? 8'hFF : 8'(k * 37 + ch * 11);
        ins = {ch[0], 3'b000, 1'b0, 3'b000};
        bus_start();
        wr_byte({5'b01011, 2'b10, 1'b0}, a0);
        wr_byte(ins, a1);
        wr_byte(dat, a2);
        bus_stop();
        model_instr(ins);
        model_data(dat);
        chk("R4 instr ack", a1, 1);
        chk("R5 data ack", a2, 1);
        check_regs("R5 data load");
        do_read(2'b10, 1, "sweep");
      end
    end

    // R8: master ACKs first byte, then NACK
    do_read(2'b10, 2, "R8 two-byte");

    // R6: instruction then STOP
    ins = 8'b1011_0000;
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(ins, a1);
    bus_stop();
    model_instr(ins);
    chk("R6 instr ack", a1, 1);
    check_regs("R6 instr only");
    ins = 8'b0000_1111;
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(ins, a1);
    bus_stop();
    model_instr(ins);
    check_regs("R6 instr only second");
    do_read(2'b10, 1, "R6 select readback");

    // R7: midscale with data in same transfer
    ins = 8'b1100_0000;
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(ins, a1);
    wr_byte(8'h11, a2);
    bus_stop();
    model_instr(ins);
    model_data(8'h11);
    chk("R7 data ack", a2, 1);
    check_regs("R7 midscale");
    chk("R7 wiper_b midscale", wiper_b, 8'h80);
    do_read(2'b10, 1, "R7 readback");

    // R10: extra byte after data
    ins = 8'b0000_0000;
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(ins, a1);
    wr_byte(8'h3C, a2);
    wr_byte(8'h99, a3);
    bus_stop();
    model_instr(ins);
    model_data(8'h3C);
    chk("R10 extra byte not acked", a3, 0);
    check_regs("R10 extra byte not applied");

    // R9: repeated START between two writes, then into a read
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(8'b1000_0000, a1);
    wr_byte(8'h5A, a2);
    model_instr(8'b1000_0000);
    model_data(8'h5A);
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    chk("R9 ack after repeated start", a0, 1);
    wr_byte(8'b0001_0000, a1);
    wr_byte(8'hA5, a2);
    bus_stop();
    model_instr(8'b0001_0000);
    model_data(8'hA5);
    check_regs("R9 repeated start writes");
    bus_start();
    wr_byte({5'b01011, 2'b10, 1'b0}, a0);
    wr_byte(8'b1000_0000, a1);
    model_instr(8'b1000_0000);
    do_read(2'b10, 1, "R9 repeated start read");
    check_regs("R9 after read");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule